// File: doc/BRIEF.md
# Three-Wire Synthesizer Frame Transmitter

This block sends one control word to a frequency synthesizer over three lines: a serial clock, a serial data line and a latch (enable) line. A controller presents a 19-bit right-aligned word and a two-bit length code, then pulses a start strobe. The block shifts out 17, 18 or 19 bits, most significant first, using a slow, lopsided bit clock whose timing is counted in whole microseconds of the system clock.

After the last bit the block lowers the data line, pulses the latch line, and reports completion with a one-cycle done pulse. The controller alone decides what each frame contains, which frames follow one another and how long to pause between them. Every duration is the product of a microsecond count and the parameter `CYCLES_PER_US`.

Top module: `synth_frame_tx`

## Requirements
- R1: After reset the serial clock, data and latch lines, `busy` and `done` are all low.
- R2: A start strobe seen while idle begins a frame, and `busy` is high from the next cycle until the cycle of the done pulse. A start strobe seen while a frame is in progress is ignored, and the waveform of that frame does not change.
- R3: The length code selects the number of bits: 0 gives 17, 1 gives 18, 2 gives 19 and 3 also gives 19. Only the low LEN bits of `frame_word` are sent, and bits above them have no effect on the lines.
- R4: Bits go out most significant first: `frame_word[LEN-1]` first and `frame_word[0]` last. Each bit is placed on the data line at the start of its slot and held until the next bit.
- R5: The data line takes each bit 2 µs before the serial clock rises. The clock is high for 2 µs and low for 10 µs between pulses, so the bit slot is 12 µs.
- R6: The data line goes low 6 µs after the falling clock edge of the last bit.
- R7: The latch line rises 2 µs after that data-low step, stays high for 2 µs, and is never high together with the clock or with the data line.
- R8: `done` is high for exactly one cycle, in the cycle in which the latch line has just returned low. `busy` is low in that cycle, and the data line then stays low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, sampled on the rising clock edge |
| frame_word | input | 19 | Frame content, right-aligned |
| len_sel | input | 2 | Length code (0:17, 1:18, 2:19, 3:19 bits) |
| ser_clk | output | 1 | Serial bit clock to the synthesizer |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_latch | output | 1 | Latch pulse that closes the frame |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse when the frame completes |

## Verification
Every system cycle of every frame is compared with a waveform computed from the length, the word and the microsecond rules. A design with a wrong setup, high or gap count therefore shows a clock edge shifted by a cycle, and a wrong bit order or an unmasked upper word bit shows the wrong data level. The bench covers all four length codes, words with set bits above the selected length, and start pulses injected mid-frame with different words. A design that accepted one of those restarts the shift and breaks the expected waveform. The tail of the frame is checked cycle by cycle as well, so a latch that overlaps the data-low step, lasts the wrong time or raises `done` in the wrong cycle is caught.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_HIGH  = 3'd2,
      ST_GAP   = 3'd3,
      ST_TRAIL = 3'd4,
      ST_DLOW  = 3'd5,
      ST_LATCH = 3'd6
   } sfx_state_t;

   function automatic int unsigned sfx_max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/sfx_phase_timer.sv
module sfx_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // a new phase may only be armed once the previous one has run out (R5)
   p_load_on_expiry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> expired);

endmodule

// File: rtl/sfx_bit_shifter.sv
module sfx_bit_shifter #(
   parameter int MAX_LEN = 19,
   parameter int LEN_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               advance,
   input  logic [MAX_LEN-1:0] word,
   input  logic [LEN_W-1:0]   len,
   output logic               load_msb,
   output logic               next_bit,
   output logic               last_bit
);

   logic [MAX_LEN-1:0] shreg_q;
   logic [MAX_LEN-1:0] shift_nx;
   logic [LEN_W-1:0]   left_q;
   logic [LEN_W-1:0]   shamt;

   // one-position left shift, built per bit
   for (genvar i = 0; i < MAX_LEN; i++) begin : g_shift
      if (i == 0) begin : g_lsb
         assign shift_nx[i] = 1'b0;
      end else begin : g_mid
         assign shift_nx[i] = shreg_q[i-1];
      end
   end

   // align bit LEN-1 of the word with the top of the register
   assign shamt    = LEN_W'(MAX_LEN) - len;
   assign load_msb = word[len - 1'b1];
   assign next_bit = shreg_q[MAX_LEN-2];
   assign last_bit = (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         left_q  <= '0;
      end else if (load) begin
         shreg_q <= word << shamt;
         left_q  <= len - 1'b1;
      end else if (advance) begin
         shreg_q <= shift_nx;
         left_q  <= left_q - 1'b1;
      end
   end

   // the frame never asks for more bits than the length code allowed (R3)
   p_no_extra_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> (left_q != '0));

endmodule

// File: rtl/sfx_sequencer.sv
module sfx_sequencer
   import sfx_pkg::*;
#(
   parameter int CYCLES_PER_US = 10,
   parameter int T_SETUP_US    = 2,
   parameter int T_HIGH_US     = 2,
   parameter int T_LOW_US      = 10,
   parameter int T_TRAIL_US    = 6,
   parameter int T_PRE_EN_US   = 2,
   parameter int T_EN_US       = 2,
   parameter int CNT_W         = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tmr_expired,
   input  logic             load_msb,
   input  logic             next_bit,
   input  logic             last_bit,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             sh_load,
   output logic             sh_adv,
   output logic             ser_clk,
   output logic             ser_data,
   output logic             ser_latch,
   output logic             busy,
   output logic             done
);

   localparam int SETUP_V = T_SETUP_US * CYCLES_PER_US - 1;
   localparam int HIGH_V  = T_HIGH_US * CYCLES_PER_US - 1;
   localparam int GAP_V   = (T_LOW_US - T_SETUP_US) * CYCLES_PER_US - 1;
   localparam int TRAIL_V = T_TRAIL_US * CYCLES_PER_US - 1;
   localparam int PRE_V   = T_PRE_EN_US * CYCLES_PER_US - 1;
   localparam int EN_V    = T_EN_US * CYCLES_PER_US - 1;

   sfx_state_t state_q, state_d;
   logic clk_d, data_d, latch_d, busy_d, done_d;

   always_comb begin
      state_d  = state_q;
      clk_d    = ser_clk;
      data_d   = ser_data;
      latch_d  = ser_latch;
      busy_d   = busy;
      done_d   = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_adv   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               sh_load  = 1'b1;
               data_d   = load_msb;
               busy_d   = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(SETUP_V);
               state_d  = ST_SETUP;
            end
         end
         ST_SETUP: begin
            if (tmr_expired) begin
               clk_d    = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(HIGH_V);
               state_d  = ST_HIGH;
            end
         end
         ST_HIGH: begin
            if (tmr_expired) begin
               clk_d    = 1'b0;
               tmr_load = 1'b1;
               if (last_bit) begin
                  tmr_val = CNT_W'(TRAIL_V);
                  state_d = ST_TRAIL;
               end else begin
                  tmr_val = CNT_W'(GAP_V);
                  state_d = ST_GAP;
               end
            end
         end
         ST_GAP: begin
            if (tmr_expired) begin
               sh_adv   = 1'b1;
               data_d   = next_bit;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(SETUP_V);
               state_d  = ST_SETUP;
            end
         end
         ST_TRAIL: begin
            if (tmr_expired) begin
               data_d   = 1'b0;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(PRE_V);
               state_d  = ST_DLOW;
            end
         end
         ST_DLOW: begin
            if (tmr_expired) begin
               latch_d  = 1'b1;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(EN_V);
               state_d  = ST_LATCH;
            end
         end
         ST_LATCH: begin
            if (tmr_expired) begin
               latch_d = 1'b0;
               done_d  = 1'b1;
               busy_d  = 1'b0;
               state_d = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ser_clk   <= 1'b0;
         ser_data  <= 1'b0;
         ser_latch <= 1'b0;
         busy      <= 1'b0;
         done      <= 1'b0;
      end else begin
         state_q   <= state_d;
         ser_clk   <= clk_d;
         ser_data  <= data_d;
         ser_latch <= latch_d;
         busy      <= busy_d;
         done      <= done_d;
      end
   end

   // data must not move while the synthesizer samples it (R5)
   p_data_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> $stable(ser_data));

   // the latch pulse happens only with clock and data low (R6, R7)
   p_latch_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ser_latch |-> (!ser_clk && !ser_data));

endmodule

// File: rtl/synth_frame_tx.sv
module synth_frame_tx
   import sfx_pkg::*;
#(
   parameter int CYCLES_PER_US = 10,
   parameter int MAX_LEN       = 19,
   parameter int LEN_CODE0     = 17,
   parameter int LEN_CODE1     = 18,
   parameter int LEN_CODE2     = 19,
   parameter int LEN_CODE3     = 19,
   parameter int T_SETUP_US    = 2,
   parameter int T_HIGH_US     = 2,
   parameter int T_LOW_US      = 10,
   parameter int T_TRAIL_US    = 6,
   parameter int T_PRE_EN_US   = 2,
   parameter int T_EN_US       = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [MAX_LEN-1:0] frame_word,
   input  logic [1:0]         len_sel,
   output logic               ser_clk,
   output logic               ser_data,
   output logic               ser_latch,
   output logic               busy,
   output logic               done
);

   localparam int LEN_W = $clog2(MAX_LEN + 1);
   localparam int MAX_US = sfx_max3(sfx_max3(T_SETUP_US, T_HIGH_US, T_LOW_US),
                                    sfx_max3(T_TRAIL_US, T_PRE_EN_US, T_EN_US), 1);
   localparam int CNT_W = $clog2(MAX_US * CYCLES_PER_US + 1);

   // elaboration-time parameter checks
   if (CYCLES_PER_US < 1) begin : g_chk_rate
      $error("CYCLES_PER_US must be at least 1");
   end
   if (MAX_LEN < 2) begin : g_chk_max
      $error("MAX_LEN must be at least 2");
   end
   if (T_LOW_US <= T_SETUP_US) begin : g_chk_low
      $error("clock low time must exceed the data setup time");
   end
   if (T_SETUP_US < 1 || T_HIGH_US < 1 || T_TRAIL_US < 1 ||
       T_PRE_EN_US < 1 || T_EN_US < 1) begin : g_chk_us
      $error("every phase must last at least one microsecond");
   end
   if (LEN_CODE0 < 1 || LEN_CODE0 > MAX_LEN || LEN_CODE1 < 1 || LEN_CODE1 > MAX_LEN ||
       LEN_CODE2 < 1 || LEN_CODE2 > MAX_LEN || LEN_CODE3 < 1 || LEN_CODE3 > MAX_LEN)
   begin : g_chk_len
      $error("frame lengths must lie between 1 and MAX_LEN");
   end

   logic [LEN_W-1:0] frame_len;
   logic             tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val;
   logic             sh_load, sh_adv;
   logic             load_msb, next_bit, last_bit;

   always_comb begin
      unique case (len_sel)
         2'd0:    frame_len = LEN_W'(LEN_CODE0);
         2'd1:    frame_len = LEN_W'(LEN_CODE1);
         2'd2:    frame_len = LEN_W'(LEN_CODE2);
         default: frame_len = LEN_W'(LEN_CODE3);
      endcase
   end

   sfx_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   sfx_bit_shifter #(
      .MAX_LEN (MAX_LEN),
      .LEN_W   (LEN_W)
   ) u_shifter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sh_load),
      .advance  (sh_adv),
      .word     (frame_word),
      .len      (frame_len),
      .load_msb (load_msb),
      .next_bit (next_bit),
      .last_bit (last_bit)
   );

   sfx_sequencer #(
      .CYCLES_PER_US (CYCLES_PER_US),
      .T_SETUP_US    (T_SETUP_US),
      .T_HIGH_US     (T_HIGH_US),
      .T_LOW_US      (T_LOW_US),
      .T_TRAIL_US    (T_TRAIL_US),
      .T_PRE_EN_US   (T_PRE_EN_US),
      .T_EN_US       (T_EN_US),
      .CNT_W         (CNT_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .tmr_expired (tmr_expired),
      .load_msb    (load_msb),
      .next_bit    (next_bit),
      .last_bit    (last_bit),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .sh_load     (sh_load),
      .sh_adv      (sh_adv),
      .ser_clk     (ser_clk),
      .ser_data    (ser_data),
      .ser_latch   (ser_latch),
      .busy        (busy),
      .done        (done)
   );

   // no frame reload once a frame is under way (R2)
   p_no_reload_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !sh_load);

   // done lasts a single cycle (R8)
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // done marks the cycle right after the latch line fell (R8)
   p_done_at_latch_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!ser_latch && $past(ser_latch) && !busy));

endmodule

// File: tb/synth_frame_tx_test.sv
module synth_frame_tx_test;

   localparam int U       = 2;
   localparam int MAX_LEN = 19;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [MAX_LEN-1:0] frame_word = '0;
   logic [1:0]         len_sel = 2'd0;
   logic               ser_clk, ser_data, ser_latch, busy, done;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   synth_frame_tx #(.CYCLES_PER_US(U)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .frame_word (frame_word),
      .len_sel    (len_sel),
      .ser_clk    (ser_clk),
      .ser_data   (ser_data),
      .ser_latch  (ser_latch),
      .busy       (busy),
      .done       (done)
   );

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int len_of(logic [1:0] code);
      case (code)
         2'd0:    return 17;
         2'd1:    return 18;
         default: return 19;
      endcase
   endfunction

   // expected {clk, data, latch, busy, done} at a cycle offset from the accepted start
   function automatic logic [4:0] expect_at(int off, int len, logic [MAX_LEN-1:0] w);
      int base, last_off, k, o;
      logic c, d, e, b, dn;
      base     = (len - 1) * 12 * U;
      last_off = base + 14 * U;
      c = 0; d = 0; e = 0; b = 0; dn = 0;
      if (off >= last_off) begin
         dn = (off == last_off);
      end else begin
         b = 1;
         k = off / (12 * U);
         o = off % (12 * U);
         if (k >= len - 1) begin
            k = len - 1;
            o = off - base;
         end
         c = (o >= 2 * U) && (o < 4 * U);
         if (k < len - 1) d = w[len - 1 - k];
         else begin
            d = (o < 10 * U) ? w[len - 1 - k] : 1'b0;
            e = (o >= 12 * U) && (o < 14 * U);
         end
      end
      return {c, d, e, b, dn};
   endfunction

   task automatic chk(string tag, logic act, logic exp, int off);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s offset %0d: actual %b expected %b", tag, off, act, exp);
      end
   endtask

   task automatic check_idle(string tag);
      chk({tag, " clk"},   ser_clk,   1'b0, -1);
      chk({tag, " data"},  ser_data,  1'b0, -1);
      chk({tag, " latch"}, ser_latch, 1'b0, -1);
      chk({tag, " busy"},  busy,      1'b0, -1);
      chk({tag, " done"},  done,      1'b0, -1);
   endtask

   // starts a frame and compares every cycle of it; inject adds ignored start pulses
   task automatic run_frame(logic [MAX_LEN-1:0] w, logic [1:0] code, bit inject);
      int len, last_off, base;
      logic [4:0] ex;
      string dtag;
      len      = len_of(code);
      base     = (len - 1) * 12 * U;
      last_off = base + 14 * U;
      frame_word = w;
      len_sel    = code;
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int off = 0; off <= last_off; off++) begin
         ex = expect_at(off, len, w);
         dtag = (off >= base + 10 * U) ? "R6 data" : "R3/R4 data";
         chk("R5 clk",   ser_clk,   ex[4], off);
         chk(dtag,       ser_data,  ex[3], off);
         chk("R7 latch", ser_latch, ex[2], off);
         chk("R2 busy",  busy,      ex[1], off);
         chk("R8 done",  done,      ex[0], off);
         if (off < last_off) begin
            if (inject && off < last_off - 2 && ($urandom % 16) == 0) begin
               start      = 1'b1;
               frame_word = MAX_LEN'($urandom);
               len_sel    = 2'($urandom);
            end else begin
               start      = 1'b0;
               frame_word = w;
               len_sel    = code;
            end
            @(negedge clk);
         end
      end
      start = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5EED_0013));
      repeat (4) @(negedge clk);
      // R1: reset values while reset is held and right after release
      check_idle("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R1 after reset");

      // R3 directed: every code, upper word bits set beyond the length
      run_frame(19'h7FFFF, 2'd0, 1'b0);
      run_frame(19'h2AAAA, 2'd1, 1'b0);
      run_frame(19'h55555, 2'd2, 1'b0);
      run_frame(19'h40001, 2'd3, 1'b0);
      run_frame(19'h00000, 2'd2, 1'b0);
      // R4 directed: single set bit at the top of a 17-bit frame, upper bits set
      run_frame(19'h70000 | 19'h10000, 2'd0, 1'b0);
      // R8: idle after a frame keeps data low
      repeat (3) begin
         @(negedge clk);
         check_idle("R8 idle");
      end
      // R2 directed: heavy start traffic during a frame
      run_frame(19'h1C3A5, 2'd1, 1'b1);

      for (int n = 0; n < 36; n++) begin
         int gap;
         run_frame(MAX_LEN'($urandom), 2'($urandom), 1'b1);
         gap = $urandom % 4;
         for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check_idle("R8 idle gap");
         end
      end
      finished = 1'b1;
   end

   initial begin
      wait (finished || cyc >= 150000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule